// File: doc/BRIEF.md
# Serial Charge-Sharing DAC Sequencer

This block sequences the switches of a two-capacitor serial DAC. Conversion is sequential, not parallel. The output capacitor is cleared first. Then the bits of the input word are applied one at a time, least significant bit first. For each bit, the input capacitor is charged to the reference (bit 1) or drained to ground (bit 0). The two capacitors are then joined, so that their charge splits evenly. Every later share halves the contribution of the bits already applied, and the most significant bit, applied last, carries half the reference.

The sequencer also keeps an ideal numeric image of the shared node as an unsigned fraction of the reference. A checker or a higher-level model can compare the analogue result against it.

One DAC clock period is two system cycles: a load phase followed by a share phase. A W-bit conversion therefore takes W DAC clocks after the clear phase.

The word arrives over a valid/ready handshake. `in_ready` is high only while the block is idle, and a word is taken on a cycle where `in_valid` and `in_ready` are both high. A producer that holds `in_valid` while the block is busy is simply stalled: its word is neither taken nor lost, and is accepted once `in_ready` returns. The result side has no back-pressure: `done` is a one-cycle pulse and `model_v` holds its value until the next word is accepted.

Top module: `chgshr_dac_seq`

## Requirements
- R1: After reset, `in_ready` is 1, and `cap_clear`, `cap_load`, `load_level`, `cap_share`, `done` and `model_v` are all 0.
- R2: A word is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the next cycle through the `done` cycle, and it is 1 again in the cycle after `done`.
- R3: In the first cycle after acceptance, `cap_clear` is 1 for exactly one cycle and `model_v` reads 0.
- R4: After the clear cycle, W load/share pairs follow: a `cap_load` cycle and then a `cap_share` cycle. During the k-th load cycle (k = 0 first), `load_level` equals bit k of the accepted word, so bit 0 (LSB) is applied first and bit W-1 (MSB) last. `load_level` is 0 outside load cycles.
- R5: No two of `cap_clear`, `cap_load` and `cap_share` are ever 1 in the same cycle.
- R6: `model_v` is a W+1 bit unsigned fraction of the reference (value = `model_v` / 2^(W+1)). At the end of each share cycle, with b the bit just loaded, it becomes (`model_v` + b·2^(W+1)) / 2. At no other time does it change, except for the clear on acceptance.
- R7: `done` is 1 for exactly one cycle, 2W+2 cycles after the acceptance edge. From then on, `model_v` equals 2·D for accepted word D (that is, D/2^W of the reference) and holds that value until the next acceptance.
- R8: `in_valid` asserted while a conversion is running, with any word, has no effect: the running result, its timing and the single `done` pulse are unchanged.
- R9: With W = 4 and the word 0101 (MSB to LSB), the final `model_v` is 10, which is 5/16 of the reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Block idle, word can be taken |
| in_word | input | W | Parallel digital word |
| cap_clear | output | 1 | Discharge the output capacitor |
| cap_load | output | 1 | Connect the input capacitor to its source |
| load_level | output | 1 | Source select during load: 1 = reference, 0 = ground |
| cap_share | output | 1 | Join the two capacitors |
| done | output | 1 | One-cycle end-of-conversion pulse |
| model_v | output | W+1 | Ideal shared-node value as a fraction of the reference |

## Verification
The hardest situation to reach from the ports is a new `in_valid` arriving mid-conversion with a different word. Such a word must leave both the running result and the bit order on `load_level` untouched. The driver holds `in_valid` high with the inverted word for the whole busy window of some conversions. It drops `in_valid` on the `done` cycle, before `in_ready` can return. The bench then checks every phase strobe cycle by cycle, checks the partial model value at each share, and checks that exactly one `done` pulse appears. All sixteen 4-bit codes are run, which covers 0101 and the all-zero and all-one ends.

// File: rtl/chgshr_pkg.sv
package chgshr_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_CLEAR = 3'd1,
    PH_LOAD  = 3'd2,
    PH_SHARE = 3'd3,
    PH_DONE  = 3'd4
  } chgshr_phase_e;
endpackage

// File: rtl/chgshr_phase_fsm.sv
module chgshr_phase_fsm
  import chgshr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output chgshr_phase_e phase
);
  localparam int IW = (W > 1) ? $clog2(W) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(W - 1);

  chgshr_phase_e phase_q;
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE:  if (start) phase_q <= PH_CLEAR;
        PH_CLEAR: begin
          phase_q <= PH_LOAD;
          idx_q   <= '0;
        end
        PH_LOAD:  phase_q <= PH_SHARE;
        PH_SHARE: begin
          if (idx_q == LAST_IDX) begin
            phase_q <= PH_DONE;
          end else begin
            idx_q   <= idx_q + 1'b1;
            phase_q <= PH_LOAD;
          end
        end
        PH_DONE:  phase_q <= PH_IDLE;
        default:  phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase = phase_q;
endmodule

// File: rtl/chgshr_bit_shifter.sv
module chgshr_bit_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] word,
  input  logic         step,
  output logic         cur_bit
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (load) begin
      sh_q <= word;
    end else if (step) begin
      sh_q <= {1'b0, sh_q[W-1:1]};
    end
  end

  assign cur_bit = sh_q[0];
endmodule

// File: rtl/chgshr_charge_model.sv
module chgshr_charge_model #(
  parameter int W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       share,
  input  logic       bit_in,
  output logic [W:0] v
);
  logic [W:0] v_q;

  // (v + b*2^(W+1)) / 2 equals v>>1 with b placed at the top bit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
    end else if (clear) begin
      v_q <= '0;
    end else if (share) begin
      v_q <= {bit_in, v_q[W:1]};
    end
  end

  assign v = v_q;
endmodule

// File: rtl/chgshr_dac_seq.sv
module chgshr_dac_seq
  import chgshr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_word,
  output logic         cap_clear,
  output logic         cap_load,
  output logic         load_level,
  output logic         cap_share,
  output logic         done,
  output logic [W:0]   model_v
);
  chgshr_phase_e phase;
  logic          accept;
  logic          cur_bit;

  assign in_ready = (phase == PH_IDLE);
  assign accept   = in_valid && in_ready;

  chgshr_phase_fsm #(.W(W)) u_fsm (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept),
    .phase (phase)
  );

  chgshr_bit_shifter #(.W(W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .word    (in_word),
    .step    (cap_share),
    .cur_bit (cur_bit)
  );

  chgshr_charge_model #(.W(W)) u_model (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (accept),
    .share  (cap_share),
    .bit_in (cur_bit),
    .v      (model_v)
  );

  assign cap_clear  = (phase == PH_CLEAR);
  assign cap_load   = (phase == PH_LOAD);
  assign cap_share  = (phase == PH_SHARE);
  assign load_level = cap_load && cur_bit;
  assign done       = (phase == PH_DONE);
endmodule

// File: rtl/chgshr_dac_seq_chk.sv
module chgshr_dac_seq_chk #(
  parameter int W = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       cap_clear,
  input logic       cap_load,
  input logic       load_level,
  input logic       cap_share,
  input logic       done,
  input logic [W:0] model_v
);
  // R5
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({cap_clear, cap_load, cap_share}) <= 1);

  // R2
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!in_ready && cap_clear));

  // R3
  clear_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_clear |=> !cap_clear);

  // R3
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_clear |-> (model_v == '0));

  // R4
  load_then_share_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_load |=> cap_share);

  // R4
  level_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_load |-> !load_level);

  // R6
  model_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_share && !(in_valid && in_ready)) |=> $stable(model_v));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && in_ready));
endmodule

bind chgshr_dac_seq chgshr_dac_seq_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .cap_clear  (cap_clear),
  .cap_load   (cap_load),
  .load_level (load_level),
  .cap_share  (cap_share),
  .done       (done),
  .model_v    (model_v)
);

// File: tb/tb_chgshr_dac_seq.sv
module tb_chgshr_dac_seq;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_word = '0;
  logic         in_ready, cap_clear, cap_load, load_level, cap_share, done;
  logic [W:0]   model_v;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit reported = 1'b0;
  int exp_q[$];

  always #10 clk = ~clk;

  chgshr_dac_seq #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .cap_clear(cap_clear), .cap_load(cap_load),
    .load_level(load_level), .cap_share(cap_share), .done(done),
    .model_v(model_v)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Monitor: compares each done result against the scoreboard queue.
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 extra done", 1, 0);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(int'(model_v) == e, "R7 result", int'(model_v), e);
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      chk(1'b0, "watchdog", cycles, 20000);
      report();
    end
  end

  task automatic convert(input logic [W-1:0] word, input bit intrude);
    int acc;
    acc = 0;
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = word;
    chk(in_ready == 1'b1, "R2 ready idle", int'(in_ready), 1);
    exp_q.push_back(2 * int'(word));
    @(negedge clk);
    if (intrude) in_word = ~word;
    else in_valid = 1'b0;
    chk(cap_clear && !cap_load && !cap_share, "R3 clear", int'(cap_clear), 1);
    chk(model_v == '0, "R3 model zero", int'(model_v), 0);
    chk(in_ready == 1'b0, "R2 busy", int'(in_ready), 0);
    for (int k = 0; k < W; k++) begin
      @(negedge clk);
      chk(cap_load && !cap_share && !cap_clear, "R4 R5 load phase", int'(cap_load), 1);
      chk(load_level == word[k], "R4 level LSB first", int'(load_level), int'(word[k]));
      @(negedge clk);
      chk(cap_share && !cap_load && !cap_clear, "R4 R5 share phase", int'(cap_share), 1);
      chk(int'(model_v) == acc, "R6 partial", int'(model_v), acc);
      acc = (acc + (int'(word[k]) << (W + 1))) / 2;
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk(done == 1'b1, "R7 done timing", int'(done), 1);
    chk(in_ready == 1'b0, "R2 busy at done", int'(in_ready), 0);
    chk(int'(model_v) == acc, "R6 final model", int'(model_v), acc);
    @(negedge clk);
    chk(done == 1'b0, "R7 R8 single pulse", int'(done), 0);
    chk(in_ready == 1'b1, "R2 ready back", int'(in_ready), 1);
    chk(int'(model_v) == 2 * int'(word), "R7 R8 hold", int'(model_v), 2 * int'(word));
  endtask

  initial begin
    #5;
    chk(in_ready && !cap_clear && !cap_load && !load_level && !cap_share && !done
        && model_v == '0, "R1 reset", int'(model_v), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !done && model_v == '0, "R1 after reset", int'(in_ready), 1);

    // R9: 0101 gives 5/16 of the reference, model value 10 of 32
    convert(4'b0101, 1'b0);
    chk(model_v == 5'd10, "R9 five sixteenths", int'(model_v), 10);

    for (int d = 0; d < 16; d++) begin
      convert(W'(d), (d % 3) == 1);
    end
    // R8: intruding request with the opposite word
    convert(4'b1001, 1'b1);
    convert(4'b1111, 1'b1);
    convert(4'b0000, 1'b0);

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all results seen", exp_q.size(), 0);
    chk(!done && in_ready, "R8 no stray conversion", int'(done), 0);
    report();
  end
endmodule